// File: doc/BRIEF.md
# Remappable Address Decoder with Wait States

This block sits between a processor's bus and the on-chip targets. It takes one access at a time, a 32-bit byte address with a read/write flag, and turns it into a single target select: flash, SRAM, the GPIO page or the general peripheral register space. It also gives the offset of the byte within that target and a ready pulse once the target's latency has passed. Flash, SRAM and GPIO sit on the fast system bus and finish one cycle after the access is accepted. The rest of the register space sits on the slower peripheral bus and finishes after two cycles.

The lowest 128 kB of the address space is an alias window. After reset it shows flash. A one-bit remap control, held inside this block, can switch the window to show SRAM instead. Software reaches that control through a fixed word in the register space. Addresses that belong to no region, and addresses in the protected boot page of flash, complete in one cycle with an error pulse. Such an access raises no select and has no side effect.

Top module: `remap_addr_decoder`

## Requirements
- R1: After reset the remap bit reads 1 (low window shows flash), `rdy`, `err` and every select are 0.
- R2: With remap bit 1, an address in 0x00000000..0x0001F7FF raises `sel_flash` with `offset` equal to the address.
- R3: With remap bit 0, an address in 0x00000000..0x0001FFFF raises `sel_sram` with `offset` equal to address bits [12:0] (the 8 kB SRAM repeats through the window).
- R4: An address in 0x00040000..0x00041FFF raises `sel_sram` with `offset` = address − 0x00040000.
- R5: An address in 0x00080000..0x0009F7FF raises `sel_flash` with `offset` = address − 0x00080000.
- R6: The boot page 0x0009F800..0x0009FFFF is never reached. The same holds for its alias 0x0001F800..0x0001FFFF while the remap bit is 1. Both complete with `err`=1, no select, `offset`=0.
- R7: Addresses 0xFFFF0000..0xFFFFFFFF form the register space with `offset` = address bits [15:0]. The page whose bits [15:8] equal 0xF4 raises `sel_gpio`. Every other word raises `sel_periph`, except the remap word.
- R8: `rdy` is high for exactly one cycle. For flash, SRAM, GPIO and error accesses it comes 1 cycle after acceptance. For peripheral and remap-word accesses it comes 2 cycles after.
- R9: Any other address completes with `err`=1 together with `rdy`, raises no select, reports `offset`=0, and a write to it leaves the remap bit unchanged.
- R10: The remap word is at 0xFFFF0220. A write loads `wdata[0]` into the remap bit when the access completes. A read returns the bit in `rdata[0]` with zeros above. It raises no external select. `rdata` is 0 for every other access.
- R11: At most one select is high at any time. The select stays steady from acceptance until `rdy`. A request presented while an access is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, taken when no access is in flight |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data (bit 0 used by the remap word) |
| sel_flash | output | 1 | Flash target select |
| sel_sram | output | 1 | SRAM target select |
| sel_gpio | output | 1 | GPIO page select |
| sel_periph | output | 1 | Peripheral register space select |
| offset | output | 17 | Byte offset within the selected target |
| rdy | output | 1 | Access complete (one-cycle pulse) |
| err | output | 1 | Access hit a reserved or unmapped address |
| rdata | output | 32 | Remap word read data, valid with `rdy` |

## Verification
A request is driven on a falling edge and is accepted at the next rising edge. From that edge the bench counts falling edges until `rdy` appears. It expects one edge for system-bus, SRAM and error accesses and two for peripheral-bus and remap-word accesses. Select, offset, `err` and `rdata` are sampled on the falling edge where `rdy` is seen, and one-hot selects are checked on that same edge. A write to the remap word takes effect at the completing edge, so the bench first reads the bit back and only then sweeps the low window again, with both remap settings.

// File: rtl/rad_pkg.sv
package rad_pkg;
  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_FLASH  = 3'd1,
    RG_SRAM   = 3'd2,
    RG_GPIO   = 3'd3,
    RG_PERIPH = 3'd4,
    RG_REMAP  = 3'd5
  } region_e;

  localparam logic [31:0] LOW_END    = 32'h0002_0000;
  localparam logic [31:0] LOW_BOOT   = 32'h0001_F800;
  localparam logic [31:0] SRAM_BASE  = 32'h0004_0000;
  localparam logic [31:0] SRAM_END   = 32'h0004_2000;
  localparam logic [31:0] FLASH_BASE = 32'h0008_0000;
  localparam logic [31:0] FLASH_USER = 32'h0009_F800;
  localparam logic [31:0] MMR_BASE   = 32'hFFFF_0000;
  localparam int          SRAM_AW    = 13;
endpackage

// File: rtl/addr_region_decode.sv
module addr_region_decode
  import rad_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 17,
  parameter logic [15:0] REMAP_OFF = 16'h0220,
  parameter logic [7:0]  GPIO_PAGE = 8'hF4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              remap_flash,
  output region_e           region,
  output logic [OFF_W-1:0]  offset,
  output logic              slow
);
  always_comb begin
    region = RG_NONE;
    offset = '0;
    if (addr < LOW_END) begin
      if (!remap_flash) begin
        region = RG_SRAM;
        offset = OFF_W'(addr[SRAM_AW-1:0]);
      end else if (addr < LOW_BOOT) begin
        region = RG_FLASH;
        offset = OFF_W'(addr);
      end
    end else if (addr >= SRAM_BASE && addr < SRAM_END) begin
      region = RG_SRAM;
      offset = OFF_W'(addr - SRAM_BASE);
    end else if (addr >= FLASH_BASE && addr < FLASH_USER) begin
      region = RG_FLASH;
      offset = OFF_W'(addr - FLASH_BASE);
    end else if (addr >= MMR_BASE) begin
      offset = OFF_W'(addr[15:0]);
      if (addr[15:0] == REMAP_OFF)      region = RG_REMAP;
      else if (addr[15:8] == GPIO_PAGE) region = RG_GPIO;
      else                              region = RG_PERIPH;
    end
  end

  assign slow = (region == RG_PERIPH) || (region == RG_REMAP);

  // R6: the protected boot alias is never decoded as flash
  always_comb begin
    a_r6_no_boot_alias: assert (!(remap_flash && addr >= LOW_BOOT && addr < LOW_END)
                                || region == RG_NONE);
  end
endmodule

// File: rtl/access_timer.sv
module access_timer (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic slow,
  output logic active,
  output logic rdy
);
  logic active_q, active_d;
  logic wait_q, wait_d;

  assign active = active_q;
  assign rdy    = active_q & ~wait_q;

  always_comb begin
    active_d = active_q;
    wait_d   = wait_q;
    if (start) begin
      active_d = 1'b1;
      wait_d   = slow;
    end else if (rdy) begin
      active_d = 1'b0;
    end else if (active_q && wait_q) begin
      wait_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wait_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      wait_q   <= wait_d;
    end
  end

  a_r8_fast_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start && !slow |=> rdy);
  a_r8_slow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    start && slow |=> !rdy ##1 rdy);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy);
endmodule

// File: rtl/remap_reg.sv
module remap_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic remap_flash
);
  logic bit_q, bit_d;

  assign remap_flash = bit_q;

  always_comb begin
    bit_d = bit_q;
    if (wr_en) bit_d = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b1;
    else        bit_q <= bit_d;
  end

  a_r9_remap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(bit_q));
endmodule

// File: rtl/remap_addr_decoder.sv
module remap_addr_decoder
  import rad_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter int          OFF_W     = 17,
  parameter logic [15:0] REMAP_OFF = 16'h0220,
  parameter logic [7:0]  GPIO_PAGE = 8'hF4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              sel_flash,
  output logic              sel_sram,
  output logic              sel_gpio,
  output logic              sel_periph,
  output logic [OFF_W-1:0]  offset,
  output logic              rdy,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  region_e            dec_region;
  logic [OFF_W-1:0]   dec_offset;
  logic               dec_slow;
  logic               remap_flash;
  logic               active;
  logic               accept;

  region_e            region_q, region_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic               we_q, we_d;
  logic               wbit_q, wbit_d;

  assign accept = req_valid & ~active;

  addr_region_decode #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .REMAP_OFF(REMAP_OFF), .GPIO_PAGE(GPIO_PAGE)
  ) u_decode (
    .addr(req_addr), .remap_flash(remap_flash),
    .region(dec_region), .offset(dec_offset), .slow(dec_slow)
  );

  access_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .slow(dec_slow),
    .active(active), .rdy(rdy)
  );

  remap_reg u_remap (
    .clk(clk), .rst_n(rst_n),
    .wr_en(rdy && region_q == RG_REMAP && we_q),
    .wr_bit(wbit_q),
    .remap_flash(remap_flash)
  );

  always_comb begin
    region_d = region_q;
    off_d    = off_q;
    we_d     = we_q;
    wbit_d   = wbit_q;
    if (accept) begin
      region_d = dec_region;
      off_d    = dec_offset;
      we_d     = req_write;
      wbit_d   = req_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      region_q <= RG_NONE;
      off_q    <= '0;
      we_q     <= 1'b0;
      wbit_q   <= 1'b0;
    end else begin
      region_q <= region_d;
      off_q    <= off_d;
      we_q     <= we_d;
      wbit_q   <= wbit_d;
    end
  end

  assign sel_flash  = active && region_q == RG_FLASH;
  assign sel_sram   = active && region_q == RG_SRAM;
  assign sel_gpio   = active && region_q == RG_GPIO;
  assign sel_periph = active && region_q == RG_PERIPH;
  assign offset     = active ? off_q : '0;
  assign err        = rdy && region_q == RG_NONE;
  assign rdata      = (rdy && region_q == RG_REMAP && !we_q)
                      ? DATA_W'(remap_flash) : '0;

  a_r11_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_flash, sel_sram, sel_gpio, sel_periph}));
  a_r9_err_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(sel_flash | sel_sram | sel_gpio | sel_periph));
  a_r11_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
    active && !rdy |=> $stable({sel_flash, sel_sram, sel_gpio, sel_periph, offset}));
  a_r9_err_with_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> rdy);
endmodule

// File: tb/remap_addr_decoder_bench.sv
module remap_addr_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [31:0] req_addr, req_wdata;
  logic        sel_flash, sel_sram, sel_gpio, sel_periph;
  logic [16:0] offset;
  logic        rdy, err;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic exp_remap;

  always #4 clk = ~clk;

  remap_addr_decoder u_remap_addr_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata),
    .sel_flash(sel_flash), .sel_sram(sel_sram), .sel_gpio(sel_gpio),
    .sel_periph(sel_periph), .offset(offset), .rdy(rdy), .err(err), .rdata(rdata)
  );

  task automatic check(input string req, input logic [31:0] a,
                       input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s addr=%08h %s actual=%0h expected=%0h", req, a, what, act, exp);
    end
  endtask

  function automatic int sel_code();
    if (sel_flash)  return 1;
    if (sel_sram)   return 2;
    if (sel_gpio)   return 3;
    if (sel_periph) return 4;
    return 0;
  endfunction

  // code: 0 none/error, 1 flash, 2 sram, 3 gpio, 4 periph, 5 remap word
  task automatic expect_of(input logic [31:0] a, input logic rm, output int code,
                           output longint off, output int lat, output string req);
    code = 0; off = 0; lat = 1; req = "R9";
    if (a < 32'h2_0000) begin
      if (!rm) begin code = 2; off = a % 8192; req = "R3"; end
      else if (a < 32'h1_F800) begin code = 1; off = a; req = "R2"; end
      else req = "R6";
    end else if (a >= 32'h4_0000 && a < 32'h4_2000) begin
      code = 2; off = a - 32'h4_0000; req = "R4";
    end else if (a >= 32'h8_0000 && a < 32'h9_F800) begin
      code = 1; off = a - 32'h8_0000; req = "R5";
    end else if (a >= 32'h9_F800 && a < 32'hA_0000) begin
      req = "R6";
    end else if (a >= 32'hFFFF_0000) begin
      off = a % 65536; req = "R7";
      if (off == 'h220) begin code = 5; lat = 2; req = "R10"; end
      else if ((off / 256) == 'hF4) code = 3;
      else begin code = 4; lat = 2; end
    end
  endtask

  task automatic access(input logic [31:0] a, input logic w, input logic [31:0] wd,
                        output int lat, output int code, output logic e,
                        output logic [16:0] o, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rdy && lat < 4) begin
      @(negedge clk);
      lat++;
    end
    check("R11", a, "onehot", $countones({sel_flash, sel_sram, sel_gpio, sel_periph}) <= 1, 1);
    code = sel_code(); e = err; o = offset; rd = rdata;
  endtask

  task automatic probe(input logic [31:0] a, input logic w, input logic [31:0] wd);
    int lat, code, ecode, elat;
    logic e;
    logic [16:0] o;
    logic [31:0] rd;
    longint eoff;
    string req;
    expect_of(a, exp_remap, ecode, eoff, elat, req);
    access(a, w, wd, lat, code, e, o, rd);
    check("R8", a, "latency", lat, elat);
    check(req, a, "select", code, (ecode == 5) ? 0 : ecode);
    check(req, a, "err", e, ecode == 0);
    check(req, a, "offset", o, eoff);
    if (ecode == 5 && !w) check("R10", a, "rdata", rd, {31'b0, exp_remap});
    else check("R10", a, "rdata zero", rd, 0);
    if (ecode == 5 && w) exp_remap = wd[0];
  endtask

  task automatic sweep();
    for (longint a = 0; a < 'h2_0000; a += 'h7F1) probe(32'(a), 1'b0, 0);
    probe(32'h1_F7FF, 0, 0); probe(32'h1_F800, 0, 0); probe(32'h1_FFFF, 0, 0);
    probe(32'h2_0000, 0, 0); probe(32'h3_FFFF, 0, 0);
    for (longint a = 'h4_0000; a < 'h4_2000; a += 'h1FF) probe(32'(a), 0, 0);
    probe(32'h4_1FFF, 0, 0); probe(32'h4_2000, 0, 0); probe(32'h7_FFFF, 0, 0);
    for (longint a = 'h8_0000; a < 'hA_0000; a += 'h1F01) probe(32'(a), 0, 0);
    probe(32'h9_F7FF, 0, 0); probe(32'h9_F800, 0, 0); probe(32'h9_FFFF, 0, 0);
    probe(32'hA_0000, 0, 0); probe(32'h1234_5678, 0, 0); probe(32'h8000_0000, 0, 0);
    probe(32'hFFFE_FFFF, 0, 0);
    for (longint a = 'hFFFF_0000; a <= 'hFFFF_FFFF; a += 'h3F1) probe(32'(a), 0, 0);
    probe(32'hFFFF_0220, 0, 0); probe(32'hFFFF_F3FF, 0, 0); probe(32'hFFFF_F400, 0, 0);
    probe(32'hFFFF_F4FF, 0, 0); probe(32'hFFFF_F500, 0, 0); probe(32'hFFFF_FFFF, 0, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_wdata = '0;
    exp_remap = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset, remap bit reads 1
    check("R1", 0, "rdy", rdy, 0);
    check("R1", 0, "err", err, 0);
    check("R1", 0, "selects", sel_code(), 0);
    probe(32'hFFFF_0220, 0, 0);
    probe(32'h0000_0100, 0, 0);

    sweep();

    // R9: writes to unmapped and GPIO leave remap bit alone
    probe(32'h1234_5678, 1, 0);
    probe(32'hFFFF_F404, 1, 0);
    probe(32'hFFFF_0224, 1, 0);
    probe(32'hFFFF_0220, 0, 0);

    // R10/R3: clear remap bit, low window now shows SRAM
    probe(32'hFFFF_0220, 1, 32'hFFFF_FFFE);
    probe(32'hFFFF_0220, 0, 0);
    sweep();
    probe(32'h1_2345, 0, 0);

    // R10/R2: set it again
    probe(32'hFFFF_0220, 1, 32'h0000_0001);
    probe(32'hFFFF_0220, 0, 0);
    probe(32'h0001_0000, 0, 0);
    probe(32'h0001_F800, 0, 0);

    // R11: request during a peripheral access is ignored
    begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'hFFFF_0400; req_write = 1'b0;
      @(negedge clk);
      req_addr = 32'h0004_0010;
      check("R11", 32'hFFFF_0400, "rdy cycle1", rdy, 0);
      check("R11", 32'hFFFF_0400, "sel cycle1", sel_code(), 4);
      @(negedge clk);
      req_valid = 1'b0;
      check("R11", 32'hFFFF_0400, "rdy cycle2", rdy, 1);
      check("R11", 32'hFFFF_0400, "sel cycle2", sel_code(), 4);
      check("R11", 32'hFFFF_0400, "offset", offset, 'h400);
      @(negedge clk);
      check("R11", 32'h0004_0010, "ignored rdy", rdy, 0);
      check("R11", 32'h0004_0010, "ignored sel", sel_code(), 0);
      @(negedge clk);
      check("R8", 32'h0004_0010, "no late rdy", rdy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule